// File: doc/BRIEF.md
# Preloaded Scaling Bitstream Accumulator

This block turns the one-bit output of a delta-sigma modulator into a multi-bit sample that already has its offset removed and its gain applied. It does no arithmetic after the measurement ends. Each measurement window starts with a wide accumulator loaded from a signed offset constant. During the window, each high modulator bit adds a gain constant into the accumulator. When the window closes, the upper half of the accumulator is the finished sample.

A dither mode lets the gain come from a four-entry table instead of a single constant. The table index advances once per add, so repeating a pattern such as 200, 201, 200, 200 gives an average gain between two integers. The window length, offset, gain, table and dither selection are sampled once at the start of each window. One window follows the next with no gap, so every modulator bit counts toward some sample.

Control is a two-state machine. `ST_IDLE` holds the accumulator quiet and moves to `ST_RUN` (transition "arm") when `enable` is high. `ST_RUN` samples the modulator every clock. At the end of each window it takes the "rollover" transition, which stays in `ST_RUN`, captures the result and preloads the next window on the same edge. It returns to `ST_IDLE` (transition "abort") as soon as `enable` falls, and the open window is discarded.

Top module: `bitstream_scaler`

## Requirements
- R1: A synchronous reset with `rst` high clears `result` to zero and `result_valid` to zero, and leaves the machine idle.
- R2: The first window begins on the clock edge that sees `enable` high in the idle state. Each window samples `mod_bit` on exactly `win_len` consecutive clock edges after its start edge, and a `win_len` of zero acts as one.
- R3: At each window start the accumulator is set to `offset_k` in its upper 16 bits and zero in its lower 16 bits, so a window with no high bits returns `offset_k` unchanged.
- R4: On each sampled edge where `mod_bit` is high, the current gain, zero-extended, is added to the full 32-bit accumulator. Low bits add nothing. `result` is the upper 16 bits of the final sum.
- R5: `result_valid` is high for exactly one cycle, the cycle after the window's last sampled edge. `result` changes only when `result_valid` is high.
- R6: The next window starts on the same edge that captures a result, so back-to-back windows lose no modulator bit.
- R7: With `dither_on` set, the gain is table entry k, held in bits [16k+15:16k] of `dither_tbl`. The index k is 0 at each window start, rises by one after each high bit, and wraps from 3 to 0.
- R8: `win_len`, `offset_k`, `gain_k`, `dither_on` and `dither_tbl` are sampled only at a window start. Changes made inside a window affect only later windows.
- R9: When `enable` is low on a clock edge in the run state, the open window is abandoned. No `result_valid` pulse follows, and `result` keeps the last captured value.
- R10: The accumulator wraps modulo 2^32, and `result` is read as a two's-complement value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run request; low abandons the open window |
| mod_bit | input | 1 | Modulator bitstream |
| win_len | input | 16 | Window length in clocks (0 acts as 1) |
| offset_k | input | 16 | Signed preload for the accumulator's upper half |
| gain_k | input | 16 | Fixed gain added per high bit |
| dither_on | input | 1 | Take the gain from the dither table |
| dither_tbl | input | 64 | Four gain entries, entry k in bits [16k+15:16k] |
| result | output | 16 | Last captured sample |
| result_valid | output | 1 | One-cycle pulse for a new sample |

## Verification
The assertions assume that `rst` is held high for at least two clock edges at start-up. They also assume that `enable` and the constant inputs change only between clock edges. The bench drives every input on the falling edge and holds reset for five cycles. It moves the constants to junk values on the first bit of each window and puts the next window's values in place on the last bit. As a result, the sampling rule of R8 is tested in every window and never relied on by chance.

// File: rtl/bss_pkg.sv
package bss_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } bss_state_e;

endpackage

// File: rtl/bss_window_timer.sv
module bss_window_timer #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             step,
    input  logic [WIN_W-1:0] len,
    output logic             last
);

    logic [WIN_W-1:0] cnt_q;

    // The window ends when the count of samples taken reaches len; len of zero ends at once.
    assign last = ({1'b0, cnt_q} + {{WIN_W{1'b0}}, 1'b1}) >= {1'b0, len};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/bss_gain_src.sv
module bss_gain_src #(
    parameter int HALF_W = 16,
    parameter int TBL_N  = 4,
    parameter int IDX_W  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      restart,
    input  logic                      hit,
    input  logic                      dither_on,
    input  logic [HALF_W-1:0]         gain_fixed,
    input  logic [TBL_N*HALF_W-1:0]   tbl,
    output logic [HALF_W-1:0]         gain_now,
    output logic [IDX_W-1:0]          idx_q
);

    logic [HALF_W-1:0] entry [TBL_N];

    for (genvar g = 0; g < TBL_N; g++) begin : g_entry
        assign entry[g] = tbl[g*HALF_W +: HALF_W];
    end

    assign gain_now = dither_on ? entry[idx_q] : gain_fixed;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (restart) begin
            idx_q <= '0;
        end else if (hit) begin
            if (idx_q == IDX_W'(TBL_N - 1)) begin
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bss_accum.sv
module bss_accum #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              preload,
    input  logic [HALF_W-1:0] offset,
    input  logic              sample,
    input  logic              hit,
    input  logic [HALF_W-1:0] addend,
    input  logic              capture,
    output logic [HALF_W-1:0] result,
    output logic              result_valid
);

    localparam int ACC_W = 2 * HALF_W;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    assign sum = acc_q + (hit ? {{HALF_W{1'b0}}, addend} : '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q        <= '0;
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= capture;
            if (capture) begin
                result <= sum[ACC_W-1:HALF_W];
            end
            if (preload) begin
                acc_q <= {offset, {HALF_W{1'b0}}};
            end else if (sample) begin
                acc_q <= sum;
            end
        end
    end

endmodule

// File: rtl/bitstream_scaler.sv
module bitstream_scaler #(
    parameter int HALF_W = 16,
    parameter int WIN_W  = 16,
    parameter int TBL_N  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enable,
    input  logic                    mod_bit,
    input  logic [WIN_W-1:0]        win_len,
    input  logic [HALF_W-1:0]       offset_k,
    input  logic [HALF_W-1:0]       gain_k,
    input  logic                    dither_on,
    input  logic [TBL_N*HALF_W-1:0] dither_tbl,
    output logic [HALF_W-1:0]       result,
    output logic                    result_valid
);

    import bss_pkg::*;

    localparam int IDX_W = (TBL_N > 1) ? $clog2(TBL_N) : 1;

    bss_state_e state_q, state_d;

    logic                    win_start;
    logic                    sample;
    logic                    capture;
    logic                    hit;
    logic                    last;
    logic [HALF_W-1:0]       gain_now;
    logic [IDX_W-1:0]        dith_idx;

    logic [WIN_W-1:0]        len_sh;
    logic [HALF_W-1:0]       gain_sh;
    logic                    dith_sh;
    logic [TBL_N*HALF_W-1:0] tbl_sh;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and control outputs
    always_comb begin
        state_d   = state_q;
        win_start = 1'b0;
        sample    = 1'b0;
        capture   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (enable) begin
                    state_d   = ST_RUN;
                    win_start = 1'b1;
                end
            end
            ST_RUN: begin
                if (enable) begin
                    sample = 1'b1;
                    if (last) begin
                        capture   = 1'b1;
                        win_start = 1'b1;
                    end
                end else begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    assign hit = sample & mod_bit;

    // Per-window copies of the constants
    always_ff @(posedge clk) begin
        if (rst) begin
            len_sh  <= '0;
            gain_sh <= '0;
            dith_sh <= 1'b0;
            tbl_sh  <= '0;
        end else if (win_start) begin
            len_sh  <= win_len;
            gain_sh <= gain_k;
            dith_sh <= dither_on;
            tbl_sh  <= dither_tbl;
        end
    end

    bss_window_timer #(
        .WIN_W (WIN_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (win_start),
        .step    (sample),
        .len     (len_sh),
        .last    (last)
    );

    bss_gain_src #(
        .HALF_W (HALF_W),
        .TBL_N  (TBL_N),
        .IDX_W  (IDX_W)
    ) u_gain (
        .clk        (clk),
        .rst        (rst),
        .restart    (win_start),
        .hit        (hit),
        .dither_on  (dith_sh),
        .gain_fixed (gain_sh),
        .tbl        (tbl_sh),
        .gain_now   (gain_now),
        .idx_q      (dith_idx)
    );

    bss_accum #(
        .HALF_W (HALF_W)
    ) u_acc (
        .clk          (clk),
        .rst          (rst),
        .preload      (win_start),
        .offset       (offset_k),
        .sample       (sample),
        .hit          (hit),
        .addend       (gain_now),
        .capture      (capture),
        .result       (result),
        .result_valid (result_valid)
    );

endmodule

// File: rtl/bss_checker.sv
module bss_checker #(
    parameter int HALF_W = 16,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              win_start,
    input logic [IDX_W-1:0]  dith_idx,
    input logic [HALF_W-1:0] result,
    input logic              result_valid
);

    p_hold_result_r5: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result));

    p_valid_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $past(enable));

    p_abort_no_valid_r9: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !result_valid);

    p_idx_restart_r7: assert property (@(posedge clk) disable iff (rst)
        win_start |=> (dith_idx == '0));

    p_rollover_r6: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $past(win_start));

endmodule

bind bitstream_scaler bss_checker #(
    .HALF_W (HALF_W),
    .IDX_W  (IDX_W)
) u_bss_checker (
    .clk          (clk),
    .rst          (rst),
    .enable       (enable),
    .win_start    (win_start),
    .dith_idx     (dith_idx),
    .result       (result),
    .result_valid (result_valid)
);

// File: tb/test_bitstream_scaler.sv
module test_bitstream_scaler;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        mod_bit = 1'b0;
    logic [15:0] win_len = '0;
    logic [15:0] offset_k = '0;
    logic [15:0] gain_k = '0;
    logic        dither_on = 1'b0;
    logic [63:0] dither_tbl = '0;
    logic [15:0] result;
    logic        result_valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    typedef struct {
        logic [15:0] v;
        int          c;
    } exp_t;

    exp_t  expq[$];
    string tagq[$];
    logic [15:0] last_exp = '0;

    logic [15:0] cur_len, nxt_len;
    logic [15:0] cur_off, nxt_off;
    logic [15:0] cur_gain, nxt_gain;
    logic        cur_dth, nxt_dth;
    logic [63:0] cur_tbl, nxt_tbl;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    bitstream_scaler i_bitstream_scaler (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .mod_bit      (mod_bit),
        .win_len      (win_len),
        .offset_k     (offset_k),
        .gain_k       (gain_k),
        .dither_on    (dither_on),
        .dither_tbl   (dither_tbl),
        .result       (result),
        .result_valid (result_valid)
    );

    // Monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (result_valid) begin
                if (expq.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R9 unexpected result_valid at cycle %0d, actual %h expected no pulse", cyc, result);
                end else begin
                    exp_t  e;
                    string t;
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    checks++;
                    if (result !== e.v) begin
                        errors++;
                        $display("FAIL %s result actual %h expected %h", t, result, e.v);
                    end
                    checks++;
                    if (cyc != e.c) begin
                        errors++;
                        $display("FAIL R5 %s pulse cycle actual %0d expected %0d", t, cyc, e.c);
                    end
                end
            end else if (expq.size() != 0 && expq[0].c <= cyc) begin
                exp_t  e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                checks++; errors++;
                $display("FAIL R5 %s missing pulse, actual none expected %h at cycle %0d", t, e.v, e.c);
            end
        end
    end

    task automatic drive_consts(input logic [15:0] l, input logic [15:0] o, input logic [15:0] g,
                                input logic d, input logic [63:0] t);
        win_len = l; offset_k = o; gain_k = g; dither_on = d; dither_tbl = t;
    endtask

    task automatic load_first(input logic [15:0] l, input logic [15:0] o, input logic [15:0] g,
                              input logic d, input logic [63:0] t);
        @(negedge clk);
        cur_len = l; cur_off = o; cur_gain = g; cur_dth = d; cur_tbl = t;
        drive_consts(l, o, g, d, t);
        enable = 1'b1;
    endtask

    task automatic set_next(input logic [15:0] l, input logic [15:0] o, input logic [15:0] g,
                            input logic d, input logic [63:0] t);
        nxt_len = l; nxt_off = o; nxt_gain = g; nxt_dth = d; nxt_tbl = t;
    endtask

    // Driver: plays one window and pushes its expected result
    task automatic play(input logic [31:0] seed, input int stop_at, input string tag);
        int          eff;
        int          idx;
        logic [31:0] acc;
        eff = (cur_len == 0) ? 1 : int'(cur_len);
        acc = {cur_off, 16'h0000};
        idx = 0;
        for (int i = 0; i < eff; i++) begin
            if (seed[i % 32]) begin
                acc = acc + {16'h0000, (cur_dth ? cur_tbl[idx*16 +: 16] : cur_gain)};
                idx = (idx + 1) % 4;
            end
        end
        for (int i = 0; i < eff; i++) begin
            @(negedge clk);
            if (stop_at >= 0 && i == stop_at) begin
                enable = 1'b0;
                return;
            end
            mod_bit = seed[i % 32];
            if (i == 0 && eff > 1) begin
                drive_consts(cur_len + 16'd3, ~cur_off, ~cur_gain, ~cur_dth, ~cur_tbl);
            end
            if (i == eff - 1) begin
                exp_t e;
                e.v = acc[31:16];
                e.c = cyc + 1;
                expq.push_back(e);
                tagq.push_back(tag);
                last_exp = acc[31:16];
                drive_consts(nxt_len, nxt_off, nxt_gain, nxt_dth, nxt_tbl);
                cur_len = nxt_len; cur_off = nxt_off; cur_gain = nxt_gain;
                cur_dth = nxt_dth; cur_tbl = nxt_tbl;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R2 watchdog expired, actual hung expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        checks++;
        if (result_valid !== 1'b0) begin
            errors++; $display("FAIL R1 result_valid actual %b expected 0", result_valid);
        end
        checks++;
        if (result !== 16'h0000) begin
            errors++; $display("FAIL R1 result actual %h expected 0000", result);
        end
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Back-to-back windows; constants are scrambled inside every window (R8)
        load_first(16'd8, 16'hFF80, 16'h0100, 1'b0, 64'h0);
        set_next(16'd5, 16'h1234, 16'h0777, 1'b0, 64'h0);
        play(32'hA53C_96E1, -1, "R4");
        set_next(16'd0, 16'h0010, 16'h8000, 1'b0, 64'h0);
        play(32'h0000_0000, -1, "R3");
        set_next(16'd1, 16'h0010, 16'h8000, 1'b0, 64'h0);
        play(32'hFFFF_FFFF, -1, "R2");
        set_next(16'd12, 16'hFFFF, 16'h5555, 1'b1,
                 {16'h1000, 16'h8000, 16'hC000, 16'h4000});
        play(32'hFFFF_FFFF, -1, "R2");
        set_next(16'd300, 16'hFFF0, 16'hFFFF, 1'b0, 64'h0);
        play(32'h0000_0BEF, -1, "R7");
        set_next(16'd20, 16'h0100, 16'h0123, 1'b0, 64'h0);
        play(32'hFFFF_FFFF, -1, "R10");
        set_next(16'd9, 16'h0042, 16'h0000, 1'b1,
                 {16'h00C8, 16'h00C8, 16'h00C9, 16'h00C8});
        play(32'h0F0F_00FF, -1, "R6");
        set_next(16'd9, 16'h0042, 16'h0000, 1'b1,
                 {16'h00C8, 16'h00C8, 16'h00C9, 16'h00C8});
        play(32'h0000_01BD, -1, "R8");
        @(negedge clk);
        enable = 1'b0;
        repeat (4) @(negedge clk);

        // R9: abandoned window
        load_first(16'd10, 16'h7000, 16'h0F00, 1'b0, 64'h0);
        play(32'hFFFF_FFFF, 4, "R9");
        repeat (15) @(negedge clk);
        checks++;
        if (result !== last_exp) begin
            errors++; $display("FAIL R9 held result actual %h expected %h", result, last_exp);
        end

        // R9: clean restart after the abort
        load_first(16'd6, 16'h0200, 16'h0011, 1'b0, 64'h0);
        set_next(16'd6, 16'h0200, 16'h0011, 1'b0, 64'h0);
        play(32'h0000_002D, -1, "R9");
        @(negedge clk);
        enable = 1'b0;
        repeat (5) @(negedge clk);

        checks++;
        if (expq.size() != 0) begin
            errors++; $display("FAIL R5 pending results actual %0d expected 0", expq.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule